// File: doc/BRIEF.md
# Per-Chip Scan-Register Bridge with Local Intercepts

This block sits in one chip's slice of the system address map and accepts 64-bit register reads and writes. It checks that an access falls inside its own chip's window, is exactly 8 bytes wide and is 8-byte aligned. It then turns the window offset into a scan-communication register index: the index is the offset shifted right by three.

A few indices never reach the downstream register bus. The identification index returns a fixed constant. Some diagnostic indices return zero on a read, and some drop a write. Every other access is sent downstream as a single request, and the bridge waits for one response or a timeout. Data crosses the boundary in big-endian byte order.

Each access finishes with a one-cycle response pulse. It also ORs a completion code into a sticky two-bit status register. Software clears that register by writing ones to the bits it wants cleared. Only one access is in flight at a time.

Top module: `scom_bridge`

## Requirements
- R1: An access is rejected when any of these holds: its address is outside the window `BASE + chip_id*2^WIN_SH` of size `2^WIN_SH`, its size is not 8, or address bits 2:0 are not zero. A rejected access raises `rsp_err` and returns zero data, sets status bits FAIL and DONE, and sends nothing downstream.
- R2: A forwarded access drives `dn_index` with window offset bits `WIN_SH-1:3` and raises `dn_valid` for exactly one cycle.
- R3: Downstream byte lane k (bits 8k+7:8k) carries upstream bits 63-8k:56-8k, so lane 0 holds bits 63:56. This applies to write data going down and to read data coming up.
- R4: A read of index 0xF000F returns `ID_VALUE` locally. A write to that index is dropped locally and reports success.
- R5: Reads of indices 0x1010C00, 0x1010C03, 0x2020007, 0x2020009 and 0x202000F, and reads of the range 0x2013F00..0x2013F07, return zero locally. Reads of any other index are forwarded.
- R6: Writes to the range 0x1010C00..0x1010C05 and to indices 0x2020007, 0x2020009 and 0x202000F are dropped locally. Writes to any other index except 0xF000F are forwarded.
- R7: Each access that succeeds sets status bit 0 (DONE). A downstream error response sets bit 1 (FAIL) and bit 0, raises `rsp_err` and returns zero data.
- R8: A response is accepted on the 1st through TIMEOUT-th clock edge after the request is issued. If no response arrives by the TIMEOUT-th edge, the access fails on that edge (FAIL and DONE). A response that arrives later is ignored.
- R9: Status bits are sticky and accumulate by OR. Writing a 1 on `stat_clr` clears that bit. A status set on the same edge as a clear of that bit wins.
- R10: `req_ready` is low from the accepting edge of a forwarded access until its response edge. A local or rejected access answers with `rsp_valid` on the accepting edge and keeps `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_id | input | CHIP_W | Chip number selecting the window |
| req_valid | input | 1 | Upstream access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | System byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Bridge can accept an access |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion failed |
| rsp_rdata | output | 64 | Read data |
| stat | output | 2 | Sticky status, bit 0 DONE, bit 1 FAIL |
| stat_clr | input | 2 | Write-1-to-clear strobe for status |
| dn_valid | output | 1 | Downstream request pulse |
| dn_write | output | 1 | Downstream request is a write |
| dn_index | output | WIN_SH-3 | Register index |
| dn_wdata | output | 64 | Byte-lane ordered write data |
| dn_resp_valid | input | 1 | Downstream response |
| dn_resp_err | input | 1 | Downstream response reports an error |
| dn_rdata | input | 64 | Byte-lane ordered read data |

## Verification
The status register can receive a completion update and a software clear on the same edge. The bench provokes this by driving `stat_clr` high in the cycle that a local access is accepted, with both status bits already set. It then expects DONE to remain set while FAIL is cleared. A second collision at the timeout edge is also exercised: a response arriving exactly on the TIMEOUT-th edge must count as a success, and one cycle later it must count as a failure. In the second case the stray response is then checked to leave both the response pulse count and the status untouched.

// File: rtl/scom_bridge.sv
module scom_bridge #(
  parameter int ADDR_W = 50,
  parameter int WIN_SH = 35,
  parameter logic [ADDR_W-1:0] BASE = 50'h3FC0_0000_0000,
  parameter int CHIP_W = 6,
  parameter int TIMEOUT = 64,
  parameter logic [63:0] ID_VALUE = 64'hC0DE_0001_2345_6789,
  localparam int IDX_W = WIN_SH - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHIP_W-1:0] chip_id,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [1:0]        stat,
  input  logic [1:0]        stat_clr,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [IDX_W-1:0]  dn_index,
  output logic [63:0]       dn_wdata,
  input  logic              dn_resp_valid,
  input  logic              dn_resp_err,
  input  logic [63:0]       dn_rdata
);
  localparam int WN_W = ADDR_W - WIN_SH;
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [WN_W-1:0] BASE_WIN = BASE[ADDR_W-1:WIN_SH];

  function automatic logic [63:0] swap8(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 8; i++) y[8*i +: 8] = x[63-8*i -: 8];
    return y;
  endfunction

  function automatic logic rd_zero(input logic [IDX_W-1:0] i);
    return i == IDX_W'(32'h1010C00) || i == IDX_W'(32'h1010C03) ||
           i == IDX_W'(32'h2020007) || i == IDX_W'(32'h2020009) ||
           i == IDX_W'(32'h202000F) ||
           (i >= IDX_W'(32'h2013F00) && i <= IDX_W'(32'h2013F07));
  endfunction

  function automatic logic wr_drop(input logic [IDX_W-1:0] i);
    return (i >= IDX_W'(32'h1010C00) && i <= IDX_W'(32'h1010C05)) ||
           i == IDX_W'(32'h2020007) || i == IDX_W'(32'h2020009) ||
           i == IDX_W'(32'h202000F);
  endfunction

  logic busy;
  logic [CW-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic hit, legal, is_id, local_hit, accept;
  logic fin, ferr;
  logic [63:0] fdata;

  assign idx       = req_addr[WIN_SH-1:3];
  assign hit       = req_addr[ADDR_W-1:WIN_SH] == BASE_WIN + WN_W'(chip_id);
  assign legal     = hit && req_size == 4'd8 && req_addr[2:0] == 3'd0;
  assign is_id     = idx == IDX_W'(32'hF000F);
  assign local_hit = !legal || is_id || (req_write ? wr_drop(idx) : rd_zero(idx));
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    fin = 1'b0;
    ferr = 1'b0;
    fdata = '0;
    if (accept && local_hit) begin
      fin = 1'b1;
      ferr = !legal;
      fdata = (legal && is_id && !req_write) ? ID_VALUE : 64'd0;
    end else if (busy && dn_resp_valid) begin
      fin = 1'b1;
      ferr = dn_resp_err;
      fdata = dn_resp_err ? 64'd0 : swap8(dn_rdata);
    end else if (busy && cnt == CW'(TIMEOUT - 1)) begin
      fin = 1'b1;
      ferr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      stat      <= '0;
      dn_valid  <= 1'b0;
      dn_write  <= 1'b0;
      dn_index  <= '0;
      dn_wdata  <= '0;
    end else begin
      rsp_valid <= fin;
      if (fin) begin
        rsp_err   <= ferr;
        rsp_rdata <= fdata;
      end
      stat     <= (stat & ~stat_clr) | (fin ? {ferr, 1'b1} : 2'b00);
      dn_valid <= 1'b0;
      if (accept && !local_hit) begin
        busy     <= 1'b1;
        cnt      <= '0;
        dn_valid <= 1'b1;
        dn_write <= req_write;
        dn_index <= idx;
        dn_wdata <= swap8(req_wdata);
      end else if (busy) begin
        if (fin) busy <= 1'b0;
        else     cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scom_bridge_checks.sv
module scom_bridge_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic [63:0] rsp_rdata,
  input logic [1:0] stat,
  input logic [1:0] stat_clr,
  input logic       dn_valid
);
  a_r2_dn_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> !dn_valid);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !req_ready);
  a_r7_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == 64'd0);
  a_r7_resp_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> stat[0]);
  a_r7_err_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> stat[1]);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !stat_clr[0]) |=> stat[0]);
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !stat_clr[1]) |=> stat[1]);
endmodule

bind scom_bridge scom_bridge_checks u_checks (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .stat(stat), .stat_clr(stat_clr),
  .dn_valid(dn_valid)
);

// File: tb/scom_bridge_test.sv
module scom_bridge_test;
  localparam logic [49:0] BASE = 50'h3FC0_0000_0000;
  localparam logic [63:0] IDV = 64'hC0DE_0001_2345_6789;
  localparam int TMO = 64;

  logic clk = 0, rst_n = 0;
  logic [5:0] chip_id = 6'd3;
  logic req_valid = 0, req_write = 0;
  logic [49:0] req_addr = '0;
  logic [3:0] req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [1:0] stat;
  logic [1:0] stat_clr = 2'b00;
  logic dn_valid, dn_write;
  logic [31:0] dn_index;
  logic [63:0] dn_wdata;
  logic dn_resp_valid = 0, dn_resp_err = 0;
  logic [63:0] dn_rdata = '0;

  int tests = 0, fails = 0, dn_count = 0, rsp_count = 0;
  int resp_lat = 2;
  logic resp_err_cfg = 0;
  logic [63:0] resp_data = 64'h1122_3344_5566_7788;
  logic [31:0] last_idx;
  logic [63:0] last_wdata;
  logic last_write;
  bit finished = 0;

  scom_bridge uut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) if (rsp_valid) rsp_count++;

  initial forever begin
    @(negedge clk);
    if (dn_valid) begin
      dn_count++;
      last_idx = dn_index; last_wdata = dn_wdata; last_write = dn_write;
      if (resp_lat != 0) begin
        repeat (resp_lat - 1) @(negedge clk);
        dn_resp_valid = 1; dn_resp_err = resp_err_cfg; dn_rdata = resp_data;
        @(negedge clk);
        dn_resp_valid = 0; dn_resp_err = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [49:0] addr_of(input int chip, input logic [31:0] idx);
    return BASE + (50'(chip) << 35) + (50'(idx) << 3);
  endfunction

  function automatic logic [63:0] bswap(input logic [63:0] x);
    logic [63:0] y;
    for (int i = 0; i < 8; i++) y[8*i +: 8] = x[63-8*i -: 8];
    return y;
  endfunction

  function automatic bit exp_rd_local(input logic [31:0] i);
    return i == 32'hF000F || i == 32'h1010C00 || i == 32'h1010C03 || i == 32'h2020007 ||
           i == 32'h2020009 || i == 32'h202000F || (i >= 32'h2013F00 && i <= 32'h2013F07);
  endfunction

  function automatic bit exp_wr_local(input logic [31:0] i);
    return i == 32'hF000F || (i >= 32'h1010C00 && i <= 32'h1010C05) ||
           i == 32'h2020007 || i == 32'h2020009 || i == 32'h202000F;
  endfunction

  logic [63:0] rd;
  logic er;
  int lat;
  bit rdy_pend;

  task automatic access(input logic w, input logic [49:0] a, input logic [3:0] sz,
                        input logic [63:0] wd, input logic [1:0] clr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd; stat_clr = clr;
    @(posedge clk); #1;
    req_valid = 0; stat_clr = 2'b00;
    lat = 1; rdy_pend = 0;
    while (!rsp_valid && lat < 500) begin
      if (req_ready) rdy_pend = 1;
      @(posedge clk); #1;
      lat++;
    end
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic clear_stat();
    @(negedge clk); stat_clr = 2'b11;
    @(negedge clk); stat_clr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] idxs [24];
    int d0, r0;
    idxs = '{32'hF000F, 32'hF000E, 32'hF0010, 32'h1010BFF, 32'h1010C00, 32'h1010C01,
             32'h1010C02, 32'h1010C03, 32'h1010C04, 32'h1010C05, 32'h1010C06, 32'h2020007,
             32'h2020008, 32'h2020009, 32'h202000E, 32'h202000F, 32'h2013EFF, 32'h2013F00,
             32'h2013F03, 32'h2013F07, 32'h2013F08, 32'h0, 32'hFFFFFFFF, 32'h2020010};
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1 && rsp_valid == 0 && dn_valid == 0, "R10 reset idle", {63'd0, req_ready}, 64'd1);
    chk(stat == 2'b00, "R9 reset status", 64'(stat), 64'd0);
    @(negedge clk); rst_n = 1;

    // R4 R5 R6 R2 R3 sweep over intercept indices and neighbours
    foreach (idxs[k]) begin
      for (int w = 0; w < 2; w++) begin
        bit loc;
        loc = w ? exp_wr_local(idxs[k]) : exp_rd_local(idxs[k]);
        clear_stat();
        d0 = dn_count;
        access(w[0], addr_of(3, idxs[k]), 4'd8, 64'h0123_4567_89AB_CDEF, 2'b00);
        chk((dn_count - d0) == (loc ? 0 : 1), w ? "R6 write forward/drop" : "R5 read forward/zero",
            64'(dn_count - d0), loc ? 64'd0 : 64'd1);
        chk(er == 0 && stat == 2'b01, "R7 done only", 64'(stat), 64'd1);
        chk(lat == (loc ? 1 : 3), "R10 latency", 64'(lat), loc ? 64'd1 : 64'd3);
        if (!w) begin
          logic [63:0] e;
          e = (idxs[k] == 32'hF000F) ? IDV : (loc ? 64'd0 : bswap(resp_data));
          chk(rd == e, idxs[k] == 32'hF000F ? "R4 id read" : "R3 R5 read data", rd, e);
        end
        if (!loc) begin
          chk(last_idx == idxs[k], "R2 index", 64'(last_idx), 64'(idxs[k]));
          chk(last_write == w[0], "R2 direction", 64'(last_write), 64'(w));
          chk(rdy_pend == 0, "R10 ready low while pending", 64'(rdy_pend), 64'd0);
          if (w) chk(last_wdata == 64'hEFCD_AB89_6745_2301, "R3 write lanes", last_wdata, 64'hEFCD_AB89_6745_2301);
        end
      end
    end

    // R1 window per chip number, size, alignment
    for (int c = 0; c < 6; c++) begin
      clear_stat(); d0 = dn_count;
      access(0, addr_of(c, 32'h1234), 4'd8, 64'd0, 2'b00);
      chk(er == (c != 3) && (dn_count - d0) == (c == 3 ? 1 : 0), "R1 window select", 64'(er), 64'(c != 3));
      chk(stat == (c == 3 ? 2'b01 : 2'b11), "R1 status", 64'(stat), c == 3 ? 64'd1 : 64'd3);
    end
    for (int s = 0; s < 16; s++) begin
      clear_stat(); d0 = dn_count;
      access(1, addr_of(3, 32'h55), s[3:0], 64'd1, 2'b00);
      chk(er == (s != 8) && (dn_count - d0) == (s == 8 ? 1 : 0), "R1 size", 64'(er), 64'(s != 8));
    end
    for (int o = 1; o < 8; o++) begin
      clear_stat(); d0 = dn_count;
      access(0, addr_of(3, 32'h55) + 50'(o), 4'd8, 64'd0, 2'b00);
      chk(er == 1 && rd == 0 && dn_count == d0 && stat == 2'b11, "R1 misaligned", 64'(stat), 64'd3);
    end
    access(0, addr_of(4, 32'h0) - 50'd8, 4'd8, 64'd0, 2'b00);
    chk(er == 0 && last_idx == 32'hFFFFFFFF, "R1 R2 last index in window", 64'(last_idx), 64'hFFFFFFFF);

    // R7 downstream error
    clear_stat(); resp_err_cfg = 1;
    access(0, addr_of(3, 32'h77), 4'd8, 64'd0, 2'b00);
    chk(er == 1 && rd == 0 && stat == 2'b11, "R7 downstream error", rd, 64'd0);
    resp_err_cfg = 0;

    // R8 timeout boundary
    clear_stat(); resp_lat = TMO;
    access(0, addr_of(3, 32'h78), 4'd8, 64'd0, 2'b00);
    chk(er == 0 && lat == TMO + 1 && rd == bswap(resp_data), "R8 response on last edge", 64'(lat), 64'(TMO + 1));
    repeat (3) @(negedge clk);
    clear_stat(); resp_lat = TMO + 1;
    access(1, addr_of(3, 32'h79), 4'd8, 64'd5, 2'b00);
    chk(er == 1 && lat == TMO + 1 && stat == 2'b11, "R8 timeout fail", 64'(stat), 64'd3);
    clear_stat(); r0 = rsp_count;
    repeat (6) @(negedge clk);
    chk(rsp_count == r0 && stat == 2'b00, "R8 late response ignored", 64'(stat), 64'd0);
    resp_lat = 0;
    access(0, addr_of(3, 32'h7A), 4'd8, 64'd0, 2'b00);
    chk(er == 1 && lat == TMO + 1, "R8 no response", 64'(lat), 64'(TMO + 1));
    resp_lat = 2;

    // R9 sticky accumulate, W1C, set wins over clear
    clear_stat();
    access(0, addr_of(9, 32'h1), 4'd8, 64'd0, 2'b00);
    access(0, addr_of(3, 32'hF000F), 4'd8, 64'd0, 2'b00);
    chk(stat == 2'b11, "R9 accumulate", 64'(stat), 64'd3);
    @(negedge clk); stat_clr = 2'b01; @(negedge clk); stat_clr = 2'b00;
    chk(stat == 2'b10, "R9 clear DONE only", 64'(stat), 64'd2);
    access(0, addr_of(3, 32'hF000F), 4'd8, 64'd0, 2'b00);
    chk(stat == 2'b11, "R9 set after partial clear", 64'(stat), 64'd3);
    access(1, addr_of(3, 32'hF000F), 4'd8, 64'd9, 2'b11);
    chk(stat == 2'b01, "R9 set wins over clear", 64'(stat), 64'd1);
    access(0, addr_of(3, 32'hF000F), 4'd8, 64'd0, 2'b00);
    chk(rd == IDV, "R4 id unchanged after write", rd, IDV);
    clear_stat(); #1;
    chk(stat == 2'b00, "R9 full clear", 64'(stat), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule